// File: doc/BRIEF.md
# USB Host Controller Power State Sequencer

This block sequences the power states of a USB host controller that holds several controller modules, each serving a group of downstream ports. Software writes a per-module control register and a per-module power configuration register over a simple write bus. The control register carries a two-bit functional-state field. The configuration register carries a port I/O-cell shutdown code, a module clock-stop bit, a PLL shutdown request and a write-one wake-clear bit. The block turns these writes into the reported functional state, per-port I/O-cell enables, per-module clock-gate enables and a PLL power-down control.

The gating controls take effect only while a module is suspended. When a module leaves suspend, its cells and clocks come back on at once. The new state is reported only once the 48 MHz clock is present again. Port events (connect, disconnect, resume signalling) on a suspended module are captured by edge-triggered flags that need no running clock. These flags drive an active-low wake request, which is the means of restarting a stopped USB clock. The request stays asserted until software clears it.

Top module: `usbpm_top`

## Requirements
- R1: After reset every module reports state 00 (reset), all I/O-cell enables and module clock enables are 1, `pll_pd` is 0 and `pme_n` is 1.
- R2: A control write to a module with bits [7:6] = 11 makes that module report 11 (suspend) after the write edge. Any other value written from a non-suspend state is reported after the write edge (00 reset, 01 resume, 10 operational).
- R3: A configuration write with bits [1:0] = 11 to a suspended module drives the I/O-cell enables of that module's ports to 0. Any other code re-enables them. The same write to a module that is not suspended is ignored.
- R4: Configuration bit 2 written to a suspended module sets that module's clock enable to 0 while the bit is 1. When the module is not suspended, the bit is ignored.
- R5: A control write with a non-suspend value to a suspended module re-enables its I/O cells and clock on the write edge. The reported state stays 11 until the first later edge at which `usb_clk_ok` is 1, and the written value is reported after that edge.
- R6: A rising edge on any connect, disconnect or resume input of a port whose module is suspended drives `pme_n` low with no clock edge needed.
- R7: Port events on a module that is not suspended leave `pme_n` unchanged.
- R8: `pme_n` stays low until a configuration write with bit 4 = 1 is made to the module owning the captured port. That write clears only that module's ports.
- R9: `pll_pd` is 1 only while every module is suspended and has configuration bit 3 set. It drops on the edge of any leave-suspend write.
- R10: Writes address one module through `wr_mod`, and the other module's state and controls are unaffected. Ports 2m and 2m+1 belong to module m.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_cfg | input | 1 | 0 selects control register, 1 selects configuration register |
| wr_mod | input | MW | Target module index |
| wr_data | input | 8 | Write data |
| evt_conn | input | NP | Per-port device connect event |
| evt_disc | input | NP | Per-port device disconnect event |
| evt_resume | input | NP | Per-port resume signalling event |
| usb_clk_ok | input | 1 | 48 MHz clock present |
| fstate | output | 2*NM | Reported functional state, two bits per module |
| io_en | output | NP | Per-port I/O-cell enable |
| mclk_en | output | NM | Per-module clock-gate enable |
| pll_pd | output | 1 | PLL power-down |
| pme_n | output | 1 | Active-low wake request |

## Verification
A module stuck in a stale internal state shows up at `fstate` one edge after the write that should have moved it. A wrong leave-pending flag either reports the new state before `usb_clk_ok` or holds `io_en` and `mclk_en` low after the leave write, both visible on the next sample. Mis-armed wake capture appears on `pme_n` within nanoseconds of a port event, with no clock needed. A bad clear routing shows as `pme_n` staying low, or releasing, one edge after a wake-clear write to the wrong module.

// File: rtl/usbpm_pkg.sv
package usbpm_pkg;

  typedef enum logic [1:0] {
    FS_RESET  = 2'b00,
    FS_RESUME = 2'b01,
    FS_OPER   = 2'b10,
    FS_SUSP   = 2'b11
  } fstate_e;

  // control register: functional-state field position
  localparam int CTRL_ST_LSB = 6;
  // configuration register fields
  localparam int CFG_IO_LSB   = 0;
  localparam int CFG_CLKSTOP  = 2;
  localparam int CFG_PLLOFF   = 3;
  localparam int CFG_WAKECLR  = 4;

  function automatic fstate_e ctrl_state(input logic [7:0] d);
    return fstate_e'(d[CTRL_ST_LSB +: 2]);
  endfunction

  function automatic logic io_off_code(input logic [7:0] d);
    return d[CFG_IO_LSB +: 2] == 2'b11;
  endfunction

endpackage

// File: rtl/usbpm_wake_cap.sv
module usbpm_wake_cap (
  input  logic rst_n,
  input  logic clr,
  input  logic arm,
  input  logic ev_conn,
  input  logic ev_disc,
  input  logic ev_resume,
  output logic flag_o
);
  // event edge clocks the flag directly: no free-running clock is needed
  logic ev_any;
  logic kill;
  assign ev_any = ev_conn | ev_disc | ev_resume;
  assign kill   = ~rst_n | clr;

  always_ff @(posedge ev_any or posedge kill) begin
    if (kill)     flag_o <= 1'b0;
    else if (arm) flag_o <= 1'b1;
  end
endmodule

// File: rtl/usbpm_mod_fsm.sv
module usbpm_mod_fsm
  import usbpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_ctrl,
  input  logic       sel_cfg,
  input  logic [7:0] wdata,
  input  logic       usb_clk_ok,
  output fstate_e    state_o,
  output logic       suspended_o,
  output logic       io_en_o,
  output logic       mclk_en_o,
  output logic       pll_req_o,
  output logic       wake_clr_o
);
  fstate_e cur, pend;
  logic leaving, io_off, clk_stop, pll_req, wclr;

  // named internal events
  logic enter_susp, leave_req, cfg_ok, leave_done;
  assign enter_susp = sel_ctrl && (ctrl_state(wdata) == FS_SUSP);
  assign leave_req  = sel_ctrl && !enter_susp && (cur == FS_SUSP);
  assign cfg_ok     = sel_cfg && (cur == FS_SUSP) && !leaving;
  assign leave_done = leaving && usb_clk_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur      <= FS_RESET;
      pend     <= FS_RESET;
      leaving  <= 1'b0;
      io_off   <= 1'b0;
      clk_stop <= 1'b0;
      pll_req  <= 1'b0;
      wclr     <= 1'b0;
    end else begin
      wclr <= sel_cfg && wdata[CFG_WAKECLR];
      if (sel_cfg) pll_req <= wdata[CFG_PLLOFF];
      if (enter_susp) begin
        cur     <= FS_SUSP;
        leaving <= 1'b0;
      end else if (leave_req) begin
        leaving  <= 1'b1;
        pend     <= ctrl_state(wdata);
        io_off   <= 1'b0;
        clk_stop <= 1'b0;
      end else if (sel_ctrl) begin
        cur <= ctrl_state(wdata);
      end else if (leave_done) begin
        cur     <= pend;
        leaving <= 1'b0;
      end
      if (cfg_ok) begin
        io_off   <= io_off_code(wdata);
        clk_stop <= wdata[CFG_CLKSTOP];
      end
    end
  end

  assign state_o     = cur;
  assign suspended_o = (cur == FS_SUSP) && !leaving;
  assign io_en_o     = !io_off;
  assign mclk_en_o   = !clk_stop;
  assign pll_req_o   = pll_req;
  assign wake_clr_o  = wclr;

  p_susp_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    enter_susp |=> (state_o == FS_SUSP));

  p_io_only_susp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !io_en_o |-> (state_o == FS_SUSP));

  p_clk_only_susp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mclk_en_o |-> (state_o == FS_SUSP));

  p_leave_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_o) == FS_SUSP && state_o != FS_SUSP)
      |-> ($past(io_en_o) && $past(mclk_en_o) && $past(usb_clk_ok)));
endmodule

// File: rtl/usbpm_top.sv
module usbpm_top
  import usbpm_pkg::*;
#(
  parameter int NM  = 2,
  parameter int PPM = 2,
  localparam int NP = NM * PPM,
  localparam int MW = (NM > 1) ? $clog2(NM) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_cfg,
  input  logic [MW-1:0]   wr_mod,
  input  logic [7:0]      wr_data,
  input  logic [NP-1:0]   evt_conn,
  input  logic [NP-1:0]   evt_disc,
  input  logic [NP-1:0]   evt_resume,
  input  logic            usb_clk_ok,
  output logic [2*NM-1:0] fstate,
  output logic [NP-1:0]   io_en,
  output logic [NM-1:0]   mclk_en,
  output logic            pll_pd,
  output logic            pme_n
);
  logic [NM-1:0] susp, pll_req, wclr, mod_io_en;
  logic [NP-1:0] flag;

  for (genvar m = 0; m < NM; m++) begin : g_mod
    fstate_e st;
    logic    sel_c, sel_g;
    assign sel_c = wr_en && !wr_cfg && (wr_mod == MW'(m));
    assign sel_g = wr_en &&  wr_cfg && (wr_mod == MW'(m));
    usbpm_mod_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel_ctrl    (sel_c),
      .sel_cfg     (sel_g),
      .wdata       (wr_data),
      .usb_clk_ok  (usb_clk_ok),
      .state_o     (st),
      .suspended_o (susp[m]),
      .io_en_o     (mod_io_en[m]),
      .mclk_en_o   (mclk_en[m]),
      .pll_req_o   (pll_req[m]),
      .wake_clr_o  (wclr[m])
    );
    assign fstate[2*m +: 2] = st;
  end

  for (genvar p = 0; p < NP; p++) begin : g_port
    assign io_en[p] = mod_io_en[p / PPM];
    usbpm_wake_cap u_cap (
      .rst_n     (rst_n),
      .clr       (wclr[p / PPM]),
      .arm       (susp[p / PPM]),
      .ev_conn   (evt_conn[p]),
      .ev_disc   (evt_disc[p]),
      .ev_resume (evt_resume[p]),
      .flag_o    (flag[p])
    );
  end

  assign pll_pd = &(susp & pll_req);
  assign pme_n  = ~|flag;

  logic clr_any;
  assign clr_any = |wclr;

  p_pll_all_susp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pll_pd |-> (fstate == {NM{FS_SUSP}}));

  p_wake_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_any && !$past(pme_n)) |-> !pme_n);
endmodule

// File: tb/usbpm_top_tb.sv
module usbpm_top_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0, wr_cfg = 0;
  logic [0:0] wr_mod = 0;
  logic [7:0] wr_data = 0;
  logic [3:0] conn = 0, disc = 0, res = 0;
  logic       clk_ok = 1;
  logic [3:0] fstate;
  logic [3:0] io_en;
  logic [1:0] mclk_en;
  logic       pll_pd, pme_n;

  int errors = 0, checks = 0, cycles = 0;

  always #5 clk = ~clk;

  usbpm_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cfg(wr_cfg), .wr_mod(wr_mod),
    .wr_data(wr_data), .evt_conn(conn), .evt_disc(disc), .evt_resume(res),
    .usb_clk_ok(clk_ok), .fstate(fstate), .io_en(io_en), .mclk_en(mclk_en),
    .pll_pd(pll_pd), .pme_n(pme_n)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // state field value as the bench sees it: bits [7:6] of control data
  function automatic logic [7:0] st_wr(input logic [1:0] s);
    return {s, 6'b0};
  endfunction

  task automatic wr(input logic cfg, input logic m, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_cfg = cfg; wr_mod = m; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse(input int kind, input int port);
    @(negedge clk);
    #1;
    if (kind == 0) conn[port] = 1; else if (kind == 1) disc[port] = 1; else res[port] = 1;
    #1;
    conn = 0; disc = 0; res = 0;
    #1;
  endtask

  task automatic t_reset;
    chk("R1 fstate", fstate, 4'h0);
    chk("R1 io_en", io_en, 4'hF);
    chk("R1 mclk_en", mclk_en, 2'b11);
    chk("R1 pll_pd", pll_pd, 1'b0);
    chk("R1 pme_n", pme_n, 1'b1);
  endtask

  task automatic t_state_writes;
    wr(0, 0, st_wr(2'b10));
    chk("R2 mod0 oper", fstate[1:0], 2'b10);
    chk("R10 mod1 untouched", fstate[3:2], 2'b00);
    wr(0, 1, st_wr(2'b01));
    chk("R2 mod1 resume", fstate[3:2], 2'b01);
    chk("R10 mod0 untouched", fstate[1:0], 2'b10);
  endtask

  task automatic t_cfg_ignored;
    wr(1, 0, 8'h07);
    chk("R3 io ignored outside suspend", io_en, 4'hF);
    chk("R4 clk stop ignored outside suspend", mclk_en, 2'b11);
  endtask

  task automatic t_unarmed_wake;
    pulse(0, 0);
    chk("R7 connect not armed", pme_n, 1'b1);
    pulse(2, 3);
    chk("R7 resume not armed", pme_n, 1'b1);
  endtask

  task automatic t_suspend_gating;
    wr(0, 0, st_wr(2'b11));
    chk("R2 mod0 suspend", fstate[1:0], 2'b11);
    chk("R10 mod1 still resume", fstate[3:2], 2'b01);
    wr(1, 0, 8'h03);
    chk("R3 io off in suspend", io_en, 4'b1100);
    chk("R4 clk still on", mclk_en, 2'b11);
    wr(1, 0, 8'h07);
    chk("R4 clk stop in suspend", mclk_en, 2'b10);
    chk("R9 pll on, mod1 awake", pll_pd, 1'b0);
  endtask

  task automatic t_pll;
    wr(0, 1, st_wr(2'b11));
    wr(1, 1, 8'h08);
    chk("R9 pll on, mod0 no request", pll_pd, 1'b0);
    wr(1, 0, 8'h0F);
    chk("R9 pll off all suspended", pll_pd, 1'b1);
    chk("R3 mod0 io still off", io_en, 4'b1100);
  endtask

  task automatic t_wake;
    pulse(1, 2);
    chk("R6 disconnect wakes, no clock edge", pme_n, 1'b0);
    repeat (3) @(negedge clk);
    chk("R8 wake held", pme_n, 1'b0);
    wr(1, 0, 8'h1F);
    chk("R8 clear of other module keeps wake", pme_n, 1'b0);
    wr(1, 1, 8'h18);
    chk("R8 owner clear releases wake", pme_n, 1'b1);
    pulse(2, 1);
    chk("R6 resume wakes", pme_n, 1'b0);
    wr(1, 0, 8'h1F);
    chk("R8 clear mod0", pme_n, 1'b1);
    pulse(0, 3);
    chk("R6 connect wakes", pme_n, 1'b0);
    wr(1, 1, 8'h18);
    chk("R8 clear mod1", pme_n, 1'b1);
  endtask

  task automatic t_leave;
    clk_ok = 0;
    wr(0, 0, st_wr(2'b10));
    chk("R5 io back on at write", io_en, 4'hF);
    chk("R5 clk back on at write", mclk_en, 2'b11);
    chk("R9 pll on at leave", pll_pd, 1'b0);
    chk("R5 state held without clock", fstate[1:0], 2'b11);
    repeat (3) @(negedge clk);
    chk("R5 state still held", fstate[1:0], 2'b11);
    clk_ok = 1;
    @(negedge clk);
    chk("R5 new state reported", fstate[1:0], 2'b10);
    wr(0, 1, st_wr(2'b01));
    chk("R5 one edge later at earliest", fstate[3:2], 2'b11);
    @(negedge clk);
    chk("R5 mod1 resume reported", fstate[3:2], 2'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_state_writes();
    t_cfg_ignored();
    t_unarmed_wake();
    t_suspend_gating();
    t_pll();
    t_wake();
    t_leave();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule